// File: doc/BRIEF.md
# USB Control Endpoint Status and Address Register

This block holds the device-side register state that a USB serial interface engine consults for its control endpoint. It keeps the seven-bit device address with its enable bit, and the endpoint-zero status/mode register. The status/mode register has four event flags and a four-bit response mode. The CPU reaches both registers through one read/write port. The engine reports protocol progress as single-cycle strobes: start of a SETUP data phase, end of an IN or OUT data transfer, and an ACK handshake sent. From the stored address and mode, the block tells the engine whether an incoming token is addressed to this device and which handshake to return.

The status/mode register carries a hardware write lock. Once the engine has changed the register, the CPU cannot overwrite it until the CPU has read it. Firmware therefore cannot silently discard an event it never saw. The SETUP flag is also protected from the start of the SETUP data phase until the ACK goes out. While the SETUP flag is set, CPU writes into the eight-byte endpoint-zero buffer are suppressed. This keeps the incoming request bytes intact.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `addr_match` is 0 and `hs_sel` is 00.
- R2: A CPU write to the status/mode register (`cpu_sel`=1) that is not locked loads bits 3:0 from the write data. It clears bits 6:4 whatever data is written, and it clears bit 7 too unless the SETUP protection window is open.
- R3: Any engine strobe locks the status/mode register. While it is locked, CPU writes to it change nothing. A CPU read of it (`cpu_rd` with `cpu_sel`=1) releases the lock from the next cycle on.
- R4: When a CPU write and an engine strobe fall in the same cycle, only the engine update takes effect, and the register is left locked.
- R5: `evt_setup_data` sets bit 7 (SETUP) and opens the protection window. While the window is open, bit 7 stays 1 through unlocked writes. `evt_ack_sent` closes the window and sets bit 4 (ACKed).
- R6: `buf_wr_ok` follows `buf_wr_req`, except that it is 0 while bit 7 is 1.
- R7: `evt_data_done` sets bit 6 (IN) when `evt_data_out`=0, and bit 5 (OUT) when `evt_data_out`=1.
- R8: A CPU write with `cpu_sel`=0 loads the address register: bit 7 is the enable, bits 6:0 the address. `bus_reset` clears it to 0x00, and wins over a write in the same cycle.
- R9: `addr_match` is 1 only when the enable bit is set and `tok_addr` equals the stored address.
- R10: `hs_sel` is 00 when `tok_valid`=0 or `addr_match`=0. The encodings are: `hs_sel` 01 ACK, 10 NAK, 11 STALL; `tok_kind` 00 SETUP, 01 IN, 10 OUT. Mode 0000 gives STALL for every token. Any other mode gives ACK for SETUP and NAK for IN and OUT. Kind 11 gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_reset | input | 1 | USB bus reset, clears the address register |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_sel | input | 1 | 0 selects the address register, 1 selects status/mode |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register contents |
| buf_wr_req | input | 1 | CPU request to write the endpoint-zero buffer |
| buf_wr_ok | output | 1 | Gated buffer write enable |
| tok_valid | input | 1 | A token is being presented |
| tok_kind | input | 2 | Token type: 00 SETUP, 01 IN, 10 OUT |
| tok_addr | input | 7 | Device address carried by the token |
| evt_setup_data | input | 1 | Strobe: SETUP data phase begins |
| evt_data_done | input | 1 | Strobe: last packet of an IN/OUT transfer received |
| evt_data_out | input | 1 | Qualifies evt_data_done: 1 OUT, 0 IN |
| evt_ack_sent | input | 1 | Strobe: ACK handshake begins |
| addr_match | output | 1 | Token is addressed to this enabled device |
| hs_sel | output | 2 | Handshake choice: 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
The lock is driven with each ordering of engine strobe, CPU write and CPU read. Three cases are compared: a write before the unlocking read, a write after it, and a write in the same cycle as a strobe. Together they separate a missing lock, a lock released too early, and the wrong winner of a collision. The SETUP path writes inside and outside the protection window and samples the buffer gate at both points, so a flag that clears too early or stays stuck shows up. Handshake selection is swept over all three token kinds under stall mode, the NAK mode and an arbitrary other mode. It is also tried with address mismatch and with the enable cleared, which separates mode decoding from address qualification.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;

    localparam int MODE_W = 4;
    localparam int DEV_AW = 7;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'b00,
        TK_IN    = 2'b01,
        TK_OUT   = 2'b10,
        TK_RSVD  = 2'b11
    } tok_e;

    localparam logic [MODE_W-1:0] MODE_STALL_ALL = '0;

    typedef struct packed {
        logic              setup;
        logic              in_rx;
        logic              out_rx;
        logic              acked;
        logic [MODE_W-1:0] mode;
        logic              lock;
        logic              guard;
    } ep0_state_t;

    typedef struct packed {
        logic              en;
        logic [DEV_AW-1:0] addr;
    } dev_addr_t;

endpackage

// File: rtl/ep0_addr_reg.sv
module ep0_addr_reg
    import usb_ep0_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [DEV_AW:0]   wdata,
    input  logic [DEV_AW-1:0] tok_addr,
    output logic [DEV_AW:0]   value_o,
    output logic              match_o
);

    dev_addr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (bus_reset) begin
            a_d = '0;
        end else if (wr_en) begin
            a_d.en   = wdata[DEV_AW];
            a_d.addr = wdata[DEV_AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign value_o = a_q;
    assign match_o = a_q.en && (tok_addr == a_q.addr);

    // R8: a bus reset leaves the register cleared on the next cycle
    a_r8_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (value_o == '0));

    // R9: no match is reported while the enable bit is low
    a_r9_disabled_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !value_o[DEV_AW] |-> !match_o);

endmodule

// File: rtl/ep0_mode_reg.sv
module ep0_mode_reg
    import usb_ep0_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [MODE_W-1:0] wdata,
    input  logic              ev_setup,
    input  logic              ev_done,
    input  logic              ev_done_out,
    input  logic              ev_ack,
    output logic [7:0]        status_o,
    output logic              locked_o,
    output logic              guard_o
);

    ep0_state_t s_d, s_q;
    logic       eng_upd;

    assign eng_upd = ev_setup || ev_done || ev_ack;

    always_comb begin
        s_d = s_q;
        if (eng_upd) begin
            s_d.lock = 1'b1;
            if (ev_setup) begin
                s_d.setup = 1'b1;
                s_d.guard = 1'b1;
            end
            if (ev_done) begin
                if (ev_done_out) s_d.out_rx = 1'b1;
                else             s_d.in_rx  = 1'b1;
            end
            if (ev_ack) begin
                s_d.acked = 1'b1;
                s_d.guard = 1'b0;
            end
        end else begin
            if (rd_en) s_d.lock = 1'b0;
            if (wr_en && !s_q.lock) begin
                s_d.setup  = s_q.guard;
                s_d.in_rx  = 1'b0;
                s_d.out_rx = 1'b0;
                s_d.acked  = 1'b0;
                s_d.mode   = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = {s_q.setup, s_q.in_rx, s_q.out_rx, s_q.acked, s_q.mode};
    assign locked_o = s_q.lock;
    assign guard_o  = s_q.guard;

    // R3: a locked register ignores a CPU write
    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && wr_en && !eng_upd) |=> $stable(status_o));

    // R4: any engine strobe leaves the register locked
    a_r4_engine_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
        eng_upd |=> locked_o);

    // R2: an accepted write clears the IN, OUT and ACKed flags
    a_r2_write_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && wr_en && !eng_upd) |=> (status_o[6:4] == 3'b000));

    // R5: the SETUP flag holds while the protection window is open
    a_r5_setup_held: assert property (@(posedge clk) disable iff (!rst_n)
        guard_o |=> status_o[7]);

endmodule

// File: rtl/ep0_hs_select.sv
module ep0_hs_select
    import usb_ep0_pkg::*;
(
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic              match,
    input  logic [MODE_W-1:0] mode,
    output hs_e               hs_o
);

    always_comb begin
        hs_o = HS_NONE;
        if (tok_valid && match && (tok_kind != TK_RSVD)) begin
            if (mode == MODE_STALL_ALL) begin
                hs_o = HS_STALL;
            end else begin
                case (tok_kind)
                    TK_SETUP: hs_o = HS_ACK;
                    TK_IN,
                    TK_OUT:   hs_o = HS_NAK;
                    default:  hs_o = HS_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
    import usb_ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic       cpu_sel,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       buf_wr_req,
    output logic       buf_wr_ok,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic [6:0] tok_addr,
    input  logic       evt_setup_data,
    input  logic       evt_data_done,
    input  logic       evt_data_out,
    input  logic       evt_ack_sent,
    output logic       addr_match,
    output logic [1:0] hs_sel
);

    logic [7:0] addr_val;
    logic [7:0] status_val;
    logic       locked;
    logic       guard;
    hs_e        hs_w;

    ep0_addr_reg u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_en     (cpu_wr && !cpu_sel),
        .wdata     (cpu_wdata),
        .tok_addr  (tok_addr),
        .value_o   (addr_val),
        .match_o   (addr_match)
    );

    ep0_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cpu_wr && cpu_sel),
        .rd_en       (cpu_rd && cpu_sel),
        .wdata       (cpu_wdata[MODE_W-1:0]),
        .ev_setup    (evt_setup_data),
        .ev_done     (evt_data_done),
        .ev_done_out (evt_data_out),
        .ev_ack      (evt_ack_sent),
        .status_o    (status_val),
        .locked_o    (locked),
        .guard_o     (guard)
    );

    ep0_hs_select u_hs (
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .match     (addr_match),
        .mode      (status_val[MODE_W-1:0]),
        .hs_o      (hs_w)
    );

    assign hs_sel    = hs_w;
    assign cpu_rdata = cpu_sel ? status_val : addr_val;
    assign buf_wr_ok = buf_wr_req && !status_val[7];

    // R10: a token that misses the address gets no handshake
    a_r10_no_match_no_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_match |-> (hs_sel == HS_NONE));

    // R5: the protection window only exists together with the lock or the SETUP flag
    a_r5_window_implies_setup: assert property (@(posedge clk) disable iff (!rst_n)
        guard |-> status_val[7]);

    // R3: a CPU read without an engine strobe releases the lock
    a_r3_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel && !evt_setup_data && !evt_data_done && !evt_ack_sent) |=> !locked);

endmodule

// File: tb/test_usb_ep0_ctrl.sv
`timescale 1ns/1ps
module test_usb_ep0_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       buf_wr_req = 1'b0;
    logic       buf_wr_ok;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = '0;
    logic [6:0] tok_addr = '0;
    logic       evt_setup_data = 1'b0, evt_data_done = 1'b0, evt_data_out = 1'b0, evt_ack_sent = 1'b0;
    logic       addr_match;
    logic [1:0] hs_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep0_ctrl i_usb_ep0_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .buf_wr_req(buf_wr_req), .buf_wr_ok(buf_wr_ok),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_addr(tok_addr),
        .evt_setup_data(evt_setup_data), .evt_data_done(evt_data_done),
        .evt_data_out(evt_data_out), .evt_ack_sent(evt_ack_sent),
        .addr_match(addr_match), .hs_sel(hs_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_sel = sel;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ev_done(input logic is_out);
        @(negedge clk);
        evt_data_done = 1'b1; evt_data_out = is_out;
        @(negedge clk);
        evt_data_done = 1'b0; evt_data_out = 1'b0;
    endtask

    task automatic tok_hs(input string req, input logic [1:0] kind, input logic [6:0] a, input logic [1:0] exp);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = kind; tok_addr = a;
        #1 check(req, {6'd0, hs_sel}, {6'd0, exp});
        tok_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(1'b0, v); check("R1 addr reg", v, 8'h00);
        rd_reg(1'b1, v); check("R1 mode reg", v, 8'h00);
        check("R1 addr_match", {7'd0, addr_match}, 8'h00);
        check("R1 hs_sel", {6'd0, hs_sel}, 8'h00);
    endtask

    task automatic t_plain_write();
        logic [7:0] v;
        wr_reg(1'b1, 8'hF5);
        rd_reg(1'b1, v); check("R2 unlocked write", v, 8'h05);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        ev_done(1'b1);
        wr_reg(1'b1, 8'h03);
        rd_reg(1'b1, v); check("R3 locked write ignored", v, 8'h25);
        wr_reg(1'b1, 8'h03);
        rd_reg(1'b1, v); check("R3 write after read unlock", v, 8'h03);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = 1'b1; cpu_wdata = 8'h07;
        evt_data_done = 1'b1; evt_data_out = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0; evt_data_done = 1'b0;
        wr_reg(1'b1, 8'h0A);
        rd_reg(1'b1, v); check("R4 engine wins and locks", v, 8'h43);
    endtask

    task automatic t_setup();
        logic [7:0] v;
        wr_reg(1'b1, 8'h01);
        @(negedge clk); evt_setup_data = 1'b1;
        @(negedge clk); evt_setup_data = 1'b0; buf_wr_req = 1'b1;
        #1 check("R6 buffer blocked", {7'd0, buf_wr_ok}, 8'h00);
        buf_wr_req = 1'b0;
        rd_reg(1'b1, v); check("R5 setup set", v, 8'h81);
        wr_reg(1'b1, 8'h02);
        rd_reg(1'b1, v); check("R5 setup protected", v, 8'h82);
        @(negedge clk); evt_ack_sent = 1'b1;
        @(negedge clk); evt_ack_sent = 1'b0;
        rd_reg(1'b1, v); check("R5 acked set", v, 8'h92);
        wr_reg(1'b1, 8'h02);
        rd_reg(1'b1, v); check("R5 setup clears after window", v, 8'h02);
        @(negedge clk); buf_wr_req = 1'b1;
        #1 check("R6 buffer allowed", {7'd0, buf_wr_ok}, 8'h01);
        buf_wr_req = 1'b0;
    endtask

    task automatic t_in_flag();
        logic [7:0] v;
        ev_done(1'b0);
        rd_reg(1'b1, v); check("R7 IN flag", v, 8'h42);
        wr_reg(1'b1, 8'h00);
        rd_reg(1'b1, v); check("R2 flags cleared", v, 8'h00);
    endtask

    task automatic t_addr();
        logic [7:0] v;
        wr_reg(1'b0, 8'h85);
        rd_reg(1'b0, v); check("R8 addr readback", v, 8'h85);
        @(negedge clk); tok_addr = 7'd5;
        #1 check("R9 match", {7'd0, addr_match}, 8'h01);
        tok_addr = 7'd6;
        #1 check("R9 mismatch", {7'd0, addr_match}, 8'h00);
        wr_reg(1'b0, 8'h05);
        tok_addr = 7'd5;
        #1 check("R9 disabled", {7'd0, addr_match}, 8'h00);
        wr_reg(1'b0, 8'h85);
        @(negedge clk);
        bus_reset = 1'b1; cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 8'hC4;
        @(negedge clk);
        bus_reset = 1'b0; cpu_wr = 1'b0;
        rd_reg(1'b0, v); check("R8 bus reset clears", v, 8'h00);
    endtask

    task automatic t_hs();
        wr_reg(1'b0, 8'h83);
        wr_reg(1'b1, 8'h00);
        tok_hs("R10 stall SETUP", 2'b00, 7'd3, 2'b11);
        tok_hs("R10 stall IN",    2'b01, 7'd3, 2'b11);
        tok_hs("R10 stall OUT",   2'b10, 7'd3, 2'b11);
        wr_reg(1'b1, 8'h01);
        tok_hs("R10 nak-mode SETUP", 2'b00, 7'd3, 2'b01);
        tok_hs("R10 nak-mode IN",    2'b01, 7'd3, 2'b10);
        tok_hs("R10 nak-mode OUT",   2'b10, 7'd3, 2'b10);
        tok_hs("R10 reserved kind",  2'b11, 7'd3, 2'b00);
        wr_reg(1'b1, 8'h09);
        tok_hs("R10 mode9 SETUP", 2'b00, 7'd3, 2'b01);
        tok_hs("R10 mode9 OUT",   2'b10, 7'd3, 2'b10);
        tok_hs("R10 mismatch",    2'b01, 7'd4, 2'b00);
        @(negedge clk); tok_addr = 7'd3; tok_kind = 2'b00;
        #1 check("R10 no token", {6'd0, hs_sel}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_write();
        t_lock();
        t_collide();
        t_setup();
        t_in_flag();
        t_addr();
        t_hs();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule